// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Detector

This block raises a flag when data has been sitting in a receive FIFO without being read for a programmable number of bus clock cycles. It sees the FIFO only through three abstract signals: a push strobe for each word written, a pop strobe for each word that software reads, and an empty indication. A 16-bit compare value sets the limit. A sticky timeout flag reports an expired limit. The flag is cleared by a pulse. An interrupt request is the flag gated by an enable bit.

Any push or pop restarts an internal count at zero. The count advances by one per clock while the FIFO holds data. When the count equals the compare value, the flag is set and the count holds there until the next push or pop. While the FIFO is empty the count is frozen. A compare value of zero switches the detector off. All logic runs on the single peripheral bus clock with an active-low reset.

A small state machine controls the detector. Its states are:
- `ST_OFF`: disabled, or no word has arrived yet.
- `ST_RUN`: counting.
- `ST_HOLD`: expired; the count holds its value.

Its transitions are:
- `restart`: any state to `ST_RUN` on a push or pop while the compare value is non-zero.
- `expire`: `ST_RUN` to `ST_HOLD` on a match.
- `disable`: any state to `ST_OFF` when the compare value is zero.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the timeout flag and the interrupt request are both 0.
- R2: With compare value N (non-zero) and the FIFO not empty, a push sampled at rising edge k, with no later push, pop or empty cycle, sets the flag at edge k+N+1 and not before.
- R3: A pop sampled at an edge restarts the count at zero, so the flag rises N+1 edges after the last pop.
- R4: A new push restarts the count at zero, so the flag rises N+1 edges after the last push.
- R5: While fifo_empty is 1, the count neither advances nor resets. When the FIFO refills, counting resumes from the held value.
- R6: While the compare value is 0, the flag is never set, however long data waits.
- R7: The flag stays 1 until a flag_clr pulse, which clears it at the next edge. A clear in the same cycle as a new match leaves the flag at 1.
- R8: irq equals flag AND irq_en, combinationally, with no extra cycle of delay.
- R9: After a match the count holds, so a cleared flag is not set again until a push or pop and a fresh full count.
- R10: A push or pop in the cycle where the count equals the compare value wins. No flag is set, and the count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_val | input | 16 | Timeout compare value; 0 disables |
| push | input | 1 | One-cycle strobe: word written into the FIFO |
| pop | input | 1 | One-cycle strobe: word read from the FIFO |
| fifo_empty | input | 1 | FIFO holds no data |
| flag_clr | input | 1 | One-cycle strobe clearing the timeout flag |
| irq_en | input | 1 | Interrupt enable |
| to_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The count reaches the compare value N exactly N edges after the restarting push or pop. The flag register captures the match one edge later, so every expiry check samples the flag just after edge N (still low) and just after edge N+1 (high). The bench drives and samples one time unit after each rising edge, so every sample falls between edges. A clear is seen one edge after its pulse. irq is combinational and is checked a single time unit after irq_en changes, with no clock edge in between. The tests for frozen counting while empty and for a restart on a match put the expected edge at the held count plus the remaining distance, and check both sides of that edge.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    localparam int unsigned CMP_W = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } rxto_state_e;

endpackage

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
    import rxto_pkg::*;
#(
    parameter int unsigned W = CMP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] cnt,
    input  logic         push,
    input  logic         pop,
    input  logic         fifo_empty,
    output rxto_state_e  state,
    output logic         restart,
    output logic         advance,
    output logic         hit
);

    rxto_state_e state_q;
    rxto_state_e state_d;
    logic        enabled;
    logic        activity;
    logic        live;

    assign enabled  = (cmp_val != '0);
    assign activity = push | pop;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enabled) begin
            state_d = ST_OFF;                 // disable
        end else if (activity) begin
            state_d = ST_RUN;                 // restart
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_RUN:  if (hit) state_d = ST_HOLD;   // expire
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Output logic
    always_comb begin
        restart = enabled & activity;
        live    = 1'b0;
        unique case (state_q)
            ST_OFF:  live = 1'b0;
            ST_RUN:  live = enabled & ~activity & ~fifo_empty;
            ST_HOLD: live = 1'b0;
            default: live = 1'b0;
        endcase
        hit     = live & (cnt == cmp_val);
        advance = live & ~hit;
    end

    assign state = state_q;

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic flag_q;

    // A set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned W = CMP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cmp_val,
    input  logic         push,
    input  logic         pop,
    input  logic         fifo_empty,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic         to_flag,
    output logic         irq
);

    rxto_state_e  state_q;
    logic [W-1:0] cnt_q;
    logic         restart;
    logic         advance;
    logic         hit;

    rxto_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_val    (cmp_val),
        .cnt        (cnt_q),
        .push       (push),
        .pop        (pop),
        .fifo_empty (fifo_empty),
        .state      (state_q),
        .restart    (restart),
        .advance    (advance),
        .hit        (hit)
    );

    rxto_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .advance (advance),
        .cnt     (cnt_q)
    );

    rxto_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hit),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (to_flag),
        .irq    (irq)
    );

endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk
    import rxto_pkg::*;
#(
    parameter int unsigned W = CMP_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cmp_val,
    input logic         push,
    input logic         pop,
    input logic         fifo_empty,
    input logic         flag_clr,
    input logic         irq_en,
    input logic         to_flag,
    input logic         irq,
    input logic [W-1:0] cnt_q,
    input rxto_state_e  state_q
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !to_flag);

    // R3, R4
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((push || pop) && cmp_val != '0) |=> (cnt_q == '0));

    // R5
    a_r5_empty_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !push && !pop) |=> $stable(cnt_q));

    // R6
    a_r6_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_val == '0 && !to_flag) |=> !to_flag);

    // R7
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !flag_clr) |=> to_flag);

    // R8
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_flag || !irq_en) |-> !irq);

    // R9
    a_r9_hold_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !push && !pop) |=> $stable(cnt_q));

    // R10
    a_r10_activity_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((push || pop) && !to_flag) |=> !to_flag);

endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_val    (cmp_val),
    .push       (push),
    .pop        (pop),
    .fifo_empty (fifo_empty),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .to_flag    (to_flag),
    .irq        (irq),
    .cnt_q      (cnt_q),
    .state_q    (state_q)
);

// File: tb/rx_idle_timeout_bench.sv
`timescale 1ns/1ps
module rx_idle_timeout_bench;

    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmp_val = '0;
    logic        push = 1'b0;
    logic        pop = 1'b0;
    logic        fifo_empty = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        to_flag;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rx_idle_timeout u_rx_idle_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_val    (cmp_val),
        .push       (push),
        .pop        (pop),
        .fifo_empty (fifo_empty),
        .flag_clr   (flag_clr),
        .irq_en     (irq_en),
        .to_flag    (to_flag),
        .irq        (irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_push();
        push = 1'b1; tick(1); push = 1'b0;
    endtask

    task automatic pulse_pop();
        pop = 1'b1; tick(1); pop = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    // Expects the last restart at the previous edge; checks edges N and N+1
    task automatic expect_expiry(input string req);
        tick(N);
        check({req, " early"}, to_flag, 1'b0);
        tick(1);
        check({req, " on time"}, to_flag, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 flag", to_flag, 1'b0);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_basic();
        cmp_val = N; irq_en = 1'b1;
        pulse_push();
        expect_expiry("R2");
        check("R8 irq enabled", irq, 1'b1);
        irq_en = 1'b0; #1;
        check("R8 irq masked", irq, 1'b0);
        irq_en = 1'b1; #1;
        check("R8 irq unmasked", irq, 1'b1);
        clear_flag();
        check("R7 cleared", to_flag, 1'b0);
        check("R8 irq follows clear", irq, 1'b0);
    endtask

    task automatic t_pop_restart();
        pulse_push(); tick(3);
        pulse_pop();
        expect_expiry("R3");
        clear_flag();
    endtask

    task automatic t_push_restart();
        pulse_push(); tick(4);
        pulse_push();
        expect_expiry("R4");
        clear_flag();
    endtask

    task automatic t_empty_freeze();
        pulse_push(); tick(2);
        fifo_empty = 1'b1; tick(20);
        check("R5 frozen no flag", to_flag, 1'b0);
        fifo_empty = 1'b0;
        tick(N - 2);
        check("R5 resume early", to_flag, 1'b0);
        tick(1);
        check("R5 resume on time", to_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_disable();
        cmp_val = 16'd0;
        pulse_push(); tick(100);
        check("R6 disabled", to_flag, 1'b0);
        cmp_val = N;
    endtask

    task automatic t_sticky();
        pulse_push(); tick(N + 1);
        tick(30);
        check("R7 sticky", to_flag, 1'b1);
        pulse_push(); tick(N);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        check("R7 set beats clear", to_flag, 1'b1);
        clear_flag();
        check("R7 clear", to_flag, 1'b0);
    endtask

    task automatic t_hold();
        pulse_push(); tick(N + 1);
        check("R9 expired", to_flag, 1'b1);
        clear_flag(); tick(60);
        check("R9 no retrigger", to_flag, 1'b0);
        pulse_pop();
        expect_expiry("R9 rearm");
        clear_flag();
    endtask

    task automatic t_collide();
        pulse_push(); tick(N);
        pulse_push();
        check("R10 push wins", to_flag, 1'b0);
        expect_expiry("R10 push restart");
        clear_flag();
        pulse_push(); tick(N);
        pulse_pop();
        check("R10 pop wins", to_flag, 1'b0);
        expect_expiry("R10 pop restart");
        clear_flag();
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_basic();
        t_pop_restart();
        t_push_restart();
        t_empty_freeze();
        t_disable();
        t_sticky();
        t_hold();
        t_collide();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule